// File: doc/BRIEF.md
# I2C Serial EEPROM Target Engine

This block is the bus-facing half of a serial EEPROM built on an internal 4096-byte array. It watches the two-wire bus through synchronisers, finds start and stop conditions, and decodes each transfer at the bit level. A transfer opens with a control byte. That byte must carry the device code and a select field that matches the three strap inputs. The block then takes a two-byte word address, accepts write data, or returns read data. It pulls SDA low only through an active-low output enable.

Write traffic goes to a separate write-cycle controller as single-cycle strobes. One strobe marks an address load, one carries each data byte with its target location, and one marks the stop that commits a write. Reads go to a synchronous memory array as one-cycle requests, and the data returns on the next cycle. None of these paths has back-pressure. Each strobe or request is valid for exactly one cycle and the receiver must take it; the bus timing cannot be stalled. While the controller reports a write cycle in progress, the block stays silent on the bus. A 12-bit location pointer persists between transfers and auto-increments.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the block releases SDA (`sda_oe_n` = 1), raises no strobe or read request, and ignores the bus until a start condition.
- R2: A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. Either one releases SDA at once. A stop pulses `wr_stop_stb` for one cycle only if the write transfer it ends delivered at least one data byte.
- R3: The first byte after a start is the control byte: bits 7..4 must be 1010, bits 3..1 must equal `strap_sel[2:0]`, and bit 0 selects read (1) or write (0). On a mismatch the byte is not acknowledged and the bus is ignored until the next start.
- R4: Every accepted byte is acknowledged by pulling SDA low across the ninth clock.
- R5: After a write control byte, the next two bytes form the word address, high byte first. Bits 7..4 of the high byte are ignored. When the low byte arrives, the pointer loads and `wr_addr_stb` pulses with the 12-bit address on `wr_addr`.
- R6: Each later byte of a write transfer pulses `wr_data_stb` with the byte on `wr_data` and the current pointer on `wr_addr`, then the pointer advances by one.
- R7: While `wr_busy` is high, no byte, the control byte included, is acknowledged or acted on.
- R8: A read control byte with no address phase starts at the stored pointer, which is one past the last location written or read.
- R9: A write control byte plus two address bytes, then a repeated start and a read control byte, returns data from the loaded address.
- R10: In a read, a master acknowledge makes the block send the next byte. The pointer advances after every byte and wraps from 0xFFF to 0x000.
- R11: A master non-acknowledge after a read byte makes the block release SDA and leave it released until the next start or stop.
- R12: Every change the block makes to SDA during a transfer comes at least `HOLD_CYC` system clocks after a falling SCL edge. The block never starts pulling SDA low while SCL is high.
- R13: A start in the middle of a byte abandons the transfer without any strobe and restarts control-byte decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_n | output | 1 | Active-low drive enable; 0 pulls SDA low |
| strap_sel | input | 3 | Chip-select straps matched against control byte bits 3..1 |
| wr_busy | input | 1 | Write cycle in progress in the controller |
| wr_addr_stb | output | 1 | One-cycle pulse: word address loaded |
| wr_data_stb | output | 1 | One-cycle pulse: write data byte received |
| wr_stop_stb | output | 1 | One-cycle pulse: stop ended a write carrying data |
| wr_addr | output | 12 | Address for the address or data strobe |
| wr_data | output | 8 | Byte for the data strobe |
| rd_req | output | 1 | One-cycle read request to the array |
| rd_addr | output | 12 | Read location |
| rd_data | input | 8 | Array data, valid the cycle after `rd_req` |

## Verification
Most internal faults show up within one byte at the ports. A control byte decoded wrongly or a wrong busy gate shows as a missing or extra acknowledge on the ninth clock of that byte. A pointer that loads, advances or wraps wrongly does not show until a later read. That read returns the wrong byte on the bus, or a later data strobe carries the wrong address. So the bench reads back after every write and reads across the top of the address space. A hold timer that is off shows as an SDA change too close to the falling SCL edge, which the bench measures against every falling edge.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  // Transfer phase of the bit engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  // Role of the byte currently being received
  typedef enum logic [1:0] {
    RK_CTRL,
    RK_AHI,
    RK_ALO,
    RK_DATA
  } rx_kind_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int SEL_W = 3;

  function automatic rx_kind_t next_kind(rx_kind_t k);
    case (k)
      RK_CTRL: return RK_AHI;
      RK_AHI:  return RK_ALO;
      default: return RK_DATA;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] scl_pipe, sda_pipe;
  logic         scl_q, sda_q;

  // Synchroniser chain per line; the bus idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[N-2:0], scl_i};
      sda_pipe <= {sda_pipe[N-2:0], sda_i};
      scl_q    <= scl_pipe[N-1];
      sda_q    <= sda_pipe[N-1];
    end
  end

  assign scl_s     = scl_pipe[N-1];
  assign sda_s     = sda_pipe[N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_hold_timer.sv
module i2c_hold_timer #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cancel,
  output logic fire
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cancel)        cnt <= '0;
    else if (arm)           cnt <= CW'(HOLD);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign fire = (cnt == CW'(1));
endmodule

// File: rtl/ee_addr_ptr.sv
module ee_addr_ptr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  // Plain binary increment wraps from all-ones to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (load)  ptr <= load_val;
    else if (inc)   ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_n,
  input  logic [SEL_W-1:0]  strap_sel,
  input  logic              wr_busy,
  output logic              wr_addr_stb,
  output logic              wr_data_stb,
  output logic              wr_stop_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  // Read data needs three cycles from the falling edge to reach the shifter
  localparam int HOLD_EFF = (HOLD_CYC < 4) ? 4 : HOLD_CYC;
  localparam int HI_W     = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, fire;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_hold_timer #(.HOLD(HOLD_EFF)) u_hold (
    .clk(clk), .rst_n(rst_n), .arm(scl_fall),
    .cancel(start_det | stop_det), .fire(fire)
  );

  phase_t          phase;
  rx_kind_t        kind;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic            rw_bit;
  logic [HI_W-1:0] hi_q;
  logic            wrote;
  logic            mack_n;
  logic            rd_pend;
  logic [ADDR_W-1:0] ptr;

  logic byte_done, ctrl_match, accept, ptr_load, ptr_inc, rd_issue;

  always_comb begin
    byte_done  = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);
    ctrl_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_sel);
    accept     = !wr_busy && ((kind != RK_CTRL) || ctrl_match);
    ptr_load   = byte_done && accept && (kind == RK_ALO);
    rd_issue   = !start_det && !stop_det && scl_fall &&
                 (((phase == PH_RX_ACK) && (kind == RK_CTRL) && rw_bit) ||
                  ((phase == PH_TX_ACK) && !mack_n));
    ptr_inc    = (byte_done && accept && (kind == RK_DATA)) || rd_issue;
  end

  ee_addr_ptr #(.AW(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load),
    .load_val({hi_q, shreg}), .inc(ptr_inc), .ptr(ptr)
  );

  // Bit engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      kind        <= RK_CTRL;
      bitcnt      <= '0;
      shreg       <= '0;
      rw_bit      <= 1'b0;
      hi_q        <= '0;
      wrote       <= 1'b0;
      mack_n      <= 1'b1;
      rd_pend     <= 1'b0;
      rd_req      <= 1'b0;
      rd_addr     <= '0;
      wr_addr_stb <= 1'b0;
      wr_data_stb <= 1'b0;
      wr_stop_stb <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_addr_stb <= 1'b0;
      wr_data_stb <= 1'b0;
      wr_stop_stb <= 1'b0;
      rd_req      <= rd_issue;
      rd_pend     <= rd_req;
      if (rd_issue) rd_addr <= ptr;

      if (start_det) begin
        phase  <= PH_RX;
        kind   <= RK_CTRL;
        bitcnt <= '0;
        wrote  <= 1'b0;
      end else if (stop_det) begin
        phase       <= PH_IDLE;
        wr_stop_stb <= wrote;
        wrote       <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise && (bitcnt < 4'd8)) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end
            if (byte_done) begin
              if (!accept) begin
                phase <= PH_IDLE;
              end else begin
                phase <= PH_RX_ACK;
                case (kind)
                  RK_CTRL: rw_bit <= shreg[0];
                  RK_AHI:  hi_q   <= shreg[HI_W-1:0];
                  RK_ALO: begin
                    wr_addr_stb <= 1'b1;
                    wr_addr     <= {hi_q, shreg};
                  end
                  default: begin
                    wr_data_stb <= 1'b1;
                    wr_addr     <= ptr;
                    wr_data     <= shreg;
                    wrote       <= 1'b1;
                  end
                endcase
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if ((kind == RK_CTRL) && rw_bit) begin
                phase <= PH_TX;
              end else begin
                phase <= PH_RX;
                kind  <= next_kind(kind);
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                phase <= PH_TX_ACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b1};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) mack_n <= sda_s;
            if (scl_fall) begin
              bitcnt <= '0;
              phase  <= mack_n ? PH_IDLE : PH_TX;
            end
          end
          default: ;
        endcase
        // Array data lands two cycles after the request is issued
        if (rd_pend && (phase == PH_TX)) shreg <= rd_data;
      end
    end
  end

  // Open-drain drive, updated only when the hold timer expires
  logic sda_oe_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sda_oe_n_q <= 1'b1;
    else if (start_det || stop_det)  sda_oe_n_q <= 1'b1;
    else if (fire)
      sda_oe_n_q <= !((phase == PH_RX_ACK) || ((phase == PH_TX) && !shreg[7]));
  end
  assign sda_oe_n = sda_oe_n_q;
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe_n,
  input logic wr_addr_stb,
  input logic wr_data_stb,
  input logic wr_stop_stb,
  input logic rd_req
);
  // R12
  low_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_n) |-> !scl_s);
  // R12
  hold_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> $stable(sda_oe_n));
  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> sda_oe_n);
  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> sda_oe_n);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_addr_stb, wr_data_stb, wr_stop_stb, rd_req}));
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .sda_oe_n(sda_oe_n),
  .wr_addr_stb(wr_addr_stb), .wr_data_stb(wr_data_stb),
  .wr_stop_stb(wr_stop_stb), .rd_req(rd_req)
);

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
  localparam int Q    = 16;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe_n, sda_line;
  logic [2:0] strap = 3'b101;
  logic wr_busy = 1'b0;
  logic wr_addr_stb, wr_data_stb, wr_stop_stb, rd_req;
  logic [11:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  assign sda_line = sda_m & sda_oe_n;

  i2c_eeprom_target #(.HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_n(sda_oe_n), .strap_sel(strap), .wr_busy(wr_busy),
    .wr_addr_stb(wr_addr_stb), .wr_data_stb(wr_data_stb),
    .wr_stop_stb(wr_stop_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic [7:0] mem [0:4095];
  logic [7:0] ref_mem [0:4095];
  int checks = 0, errors = 0;
  int n_addr = 0, n_data = 0, n_stop = 0, n_strobe = 0, hold_viol = 0;
  logic [11:0] last_aaddr, last_waddr;
  logic [7:0]  last_wdata;
  int since_fall = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b1;
  bit done = 0;

  // Array model: synchronous read
  always @(posedge clk) if (rd_req) rd_data <= mem[rd_addr];

  // Port monitor and write commit
  always @(negedge clk) begin
    if (wr_data_stb) begin
      mem[wr_addr] = wr_data; n_data++; last_waddr = wr_addr; last_wdata = wr_data;
    end
    if (wr_addr_stb) begin n_addr++; last_aaddr = wr_addr; end
    if (wr_stop_stb) n_stop++;
    if (wr_addr_stb | wr_data_stb | wr_stop_stb | rd_req) n_strobe++;
    if (scl_prev && !scl_m) since_fall = 0; else since_fall++;
    if (rst_n && (sda_oe_n != oe_prev) && !scl_m && since_fall < HOLD) hold_viol++;
    scl_prev = scl_m;
    oe_prev  = sda_oe_n;
  end

  function automatic logic [7:0] ctrl_byte(bit rw, logic [2:0] sel);
    return {4'b1010, sel, rw};
  endfunction
  function automatic logic [11:0] word_addr(logic [7:0] hi, logic [7:0] lo);
    return {hi[3:0], lo};
  endfunction
  function automatic logic [7:0] seed_val(int i);
    return 8'((i * 37 + 11) ^ (i >> 4));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart; sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q); endtask
  task automatic bstop;  sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q); endtask
  task automatic send_bit(input bit b); sda_m = b; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); endtask
  task automatic recv_bit(output bit b); sda_m = 1; tick(Q); scl_m = 1; tick(Q); b = sda_line; tick(Q); scl_m = 0; tick(Q); endtask
  task automatic wbyte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b); ack = !b;
  endtask
  task automatic rbyte(output logic [7:0] v, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!mack);
  endtask
  task automatic set_addr(input logic [11:0] a, input logic [3:0] junk, output bit ok);
    bit a0, a1, a2;
    bstart;
    wbyte(ctrl_byte(0, strap), a0);
    wbyte({junk, a[11:8]}, a1);
    wbyte(a[7:0], a2);
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack, ok;
    logic [7:0] v;
    logic [11:0] ptr_exp;
    int n0;
    for (int i = 0; i < 4096; i++) begin mem[i] = seed_val(i); ref_mem[i] = seed_val(i); end
    void'($urandom(32'h5EED));
    tick(5);
    chk(sda_oe_n === 1'b1, "R1", "sda released in reset", sda_oe_n, 1);
    rst_n = 1;
    tick(20);
    chk(sda_oe_n === 1'b1 && n_strobe == 0, "R1", "idle after reset", n_strobe, 0);

    // Byte write with ignored upper address nibble
    bstart;
    wbyte(ctrl_byte(0, strap), ack); chk(ack, "R3", "ack matching control", ack, 1);
    wbyte(8'hF1, ack); chk(ack, "R4", "ack address high", ack, 1);
    wbyte(8'h23, ack); chk(ack, "R4", "ack address low", ack, 1);
    chk(n_addr == 1 && last_aaddr == word_addr(8'hF1, 8'h23), "R5", "address strobe", last_aaddr, 12'h123);
    wbyte(8'hA5, ack); chk(ack, "R4", "ack data", ack, 1);
    chk(n_data == 1 && last_waddr == 12'h123 && last_wdata == 8'hA5, "R6", "data strobe", last_wdata, 8'hA5);
    bstop; tick(4);
    chk(n_stop == 1, "R2", "stop strobe after write", n_stop, 1);
    ref_mem[12'h123] = 8'hA5; ptr_exp = 12'h124;

    // Current address read, then NACK release
    bstart;
    wbyte(ctrl_byte(1, strap), ack); chk(ack, "R3", "ack read control", ack, 1);
    rbyte(v, 0);
    chk(v == ref_mem[ptr_exp], "R8", "current address read", v, ref_mem[ptr_exp]);
    ptr_exp = ptr_exp + 1;
    chk(sda_oe_n === 1'b1, "R11", "released after nack", sda_oe_n, 1);
    recv_bit(ack);
    chk(ack == 1'b1, "R11", "silent on extra clock", ack, 1);
    bstop;

    // Random read of the written byte
    set_addr(12'h123, 4'h7, ok); chk(ok, "R9", "address phase acked", ok, 1);
    bstart;
    wbyte(ctrl_byte(1, strap), ack);
    rbyte(v, 0); bstop;
    chk(v == 8'hA5, "R9", "random read data", v, 8'hA5);

    // Sequential read across the top of the space
    set_addr(12'hFFE, 4'h0, ok);
    bstart; wbyte(ctrl_byte(1, strap), ack);
    for (int k = 0; k < 4; k++) begin
      rbyte(v, k < 3);
      chk(v == ref_mem[12'((12'hFFE + k))], "R10", "sequential wrap data", v, ref_mem[12'((12'hFFE + k))]);
    end
    bstop;
    bstart; wbyte(ctrl_byte(1, strap), ack); rbyte(v, 0); bstop;
    chk(v == ref_mem[12'h002], "R10", "pointer after wrap", v, ref_mem[12'h002]);

    // Wrong device code and wrong straps
    n0 = n_addr;
    bstart; wbyte(8'b1011_1010, ack); chk(!ack, "R3", "no ack bad code", ack, 0);
    wbyte(8'h00, ack); chk(!ack, "R3", "ignored until start", ack, 0);
    bstop;
    bstart; wbyte(ctrl_byte(0, 3'b100), ack); chk(!ack, "R3", "no ack bad strap", ack, 0);
    wbyte(8'h01, ack); bstop;
    chk(n_addr == n0, "R3", "no address strobe when unselected", n_addr, n0);

    // Busy: silent, then poll succeeds; empty write gives no stop strobe
    n0 = n_stop;
    wr_busy = 1;
    bstart; wbyte(ctrl_byte(0, strap), ack); chk(!ack, "R7", "no ack while busy", ack, 0);
    bstop; wr_busy = 0;
    bstart; wbyte(ctrl_byte(0, strap), ack); chk(ack, "R7", "ack after busy", ack, 1);
    bstop; tick(4);
    chk(n_stop == n0, "R2", "no stop strobe without data", n_stop, n0);

    // Start inside a control byte, then inside a data byte
    bstart; send_bit(1); send_bit(0); send_bit(1);
    bstart; wbyte(ctrl_byte(0, strap), ack); chk(ack, "R13", "decode restarts", ack, 1);
    wbyte(8'h02, ack); wbyte(8'hAB, ack); wbyte(8'h5C, ack); bstop; tick(4);
    chk(last_waddr == 12'h2AB && last_wdata == 8'h5C, "R13", "write after abort", last_waddr, 12'h2AB);
    ref_mem[12'h2AB] = 8'h5C;
    n0 = n_data;
    set_addr(12'h300, 4'h0, ok);
    send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    bstart; bstop; tick(4);
    chk(n_data == n0 && n_stop == 2, "R13", "no strobe after aborted byte", n_data, n0);
    bstart; wbyte(ctrl_byte(1, strap), ack); rbyte(v, 0); bstop;
    chk(v == ref_mem[12'h300], "R8", "pointer set by address only", v, ref_mem[12'h300]);

    // Constrained random write then read-back
    for (int it = 0; it < 12; it++) begin
      logic [11:0] a;
      int n;
      a = 12'($urandom % 4096);
      n = 1 + int'($urandom % 4);
      set_addr(a, 4'($urandom), ok);
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        wbyte(d, ack);
        ref_mem[12'(a + k)] = d;
      end
      bstop; tick(4);
      chk(last_waddr == 12'(a + n - 1), "R6", "last data strobe address", last_waddr, 12'(a + n - 1));
      set_addr(a, 4'h0, ok);
      bstart; wbyte(ctrl_byte(1, strap), ack);
      for (int k = 0; k < n; k++) begin
        rbyte(v, k < n - 1);
        chk(v == ref_mem[12'(a + k)], "R9", "random readback", v, ref_mem[12'(a + k)]);
      end
      bstop;
    end

    chk(hold_viol == 0, "R12", "sda hold after scl fall", hold_viol, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule